// File: doc/BRIEF.md
# Grouped Secure Interrupt Distributor

This block collects level-sensitive requests from a parameterized set of interrupt sources and presents the most urgent one to a single CPU interface. Every source carries a security group bit. Group 0 sources are secure. Group 1 sources are non-secure. A secure source is signalled on the fast-interrupt line `fiq_o` or on the normal line `irq_o`, depending on one secure-only routing bit. A non-secure source can only ever raise `irq_o`.

Software sets the per-source enable, priority and group through a small register port. Each register access is tagged secure or non-secure. The CPU side claims the winning source with an acknowledge strobe and releases it with an end-of-interrupt strobe. Only one interrupt is active at a time. While it is active, the outputs stay low.

None of the interfaces uses flow control. The block accepts every strobe in the cycle it is presented. Its responses (`rd_valid_o`, `ack_valid_o`) are one-cycle pulses, and the requester must capture them: there is no back-pressure.

Top module: `sgrp_irq_dist`

## Requirements
- R1: After reset, every source is in group 0, disabled and at priority 0. The routing bit is 1 (secure to FIQ). `irq_o`, `fiq_o`, `ack_valid_o` and `rd_valid_o` are all low.
- R2: A source is a candidate when its level input is high and it is enabled. The candidate with the lowest numeric priority wins. When priorities tie, the lowest source ID wins.
- R3: The outputs are registered and reflect the inputs and configuration of the previous cycle. A group 0 winner drives `fiq_o` when the routing bit is 1 and `irq_o` when it is 0. A group 1 winner drives only `irq_o`. The two outputs are never high together.
- R4: The register port selects a field with `reg_fld_i`: 0 enable (wdata bit 0), 1 priority (wdata), 2 group (wdata bit 0, 1 = non-secure), 3 routing (wdata bit 0, ignores the ID). Group and routing fields can only be written by secure accesses. Non-secure reads of these fields return 0, and non-secure writes leave them unchanged.
- R5: A non-secure access may read and write the enable and priority fields of group 1 sources only. For group 0 sources, those fields read as 0 and writes are ignored. Accesses with an ID at or above the source count read 0 and write nothing.
- R6: A read strobe produces `rd_valid_o` with the field value one cycle later.
- R7: Suppose an acknowledge arrives with no interrupt active, a winner present, and the winner visible to the requester. The requester is secure, or the winner is in group 1. Then one cycle later `ack_valid_o` pulses with `ack_id_o` set to the winner ID. That source becomes active, and `irq_o` and `fiq_o` are low in that same cycle.
- R8: Any other acknowledge returns the spurious ID 1023 and changes nothing. This covers nothing pending, a non-secure acknowledge of a group 0 winner, and an interrupt already active.
- R9: An end-of-interrupt whose ID equals the active ID clears the active state. An end-of-interrupt with any other ID is ignored.
- R10: A source whose level stays high is signalled again after its end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level_i | input | N_SRC | Level request per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sec_i | input | 1 | Access is secure |
| reg_fld_i | input | 2 | Field select (see R4) |
| reg_id_i | input | 10 | Source ID of the access |
| reg_wdata_i | input | PRIO_W | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | PRIO_W | Read data |
| ack_i | input | 1 | Acknowledge strobe |
| ack_sec_i | input | 1 | Acknowledge comes from the secure world |
| ack_valid_o | output | 1 | Acknowledge response pulse |
| ack_id_o | output | 10 | Acknowledged ID or 1023 |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | 10 | ID being completed |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The bench compares results against a model held in the bench. A corrupted group or routing bit shows up within two cycles of the next request from that source. It appears as a line swap between `irq_o` and `fiq_o`, or as a spurious ID returned to a non-secure acknowledge. A priority or enable fault surfaces as the wrong winner ID on the next acknowledge. A stuck active flag either holds both lines low after the end-of-interrupt or lets a second acknowledge succeed. Read-back through the register port exposes silent config corruption one cycle after the read.

// File: rtl/sgrp_pkg.sv
package sgrp_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    FLD_ENABLE = 2'd0,
    FLD_PRIO   = 2'd1,
    FLD_GROUP  = 2'd2,
    FLD_ROUTE  = 2'd3
  } fld_e;
endpackage

// File: rtl/sgrp_cfg.sv
module sgrp_cfg
  import sgrp_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic            sec_i,
  input  fld_e            fld_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [PW-1:0]   wdata_i,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    grp_o,
  output logic [N*PW-1:0] prio_o,
  output logic            route_fiq_o,
  output logic            rvalid_o,
  output logic [PW-1:0]   rdata_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]    en_q, grp_q;
  logic [N*PW-1:0] pr_q;
  logic            route_q;
  logic            in_range, may_touch;
  logic [IW-1:0]   idx;
  logic [PW-1:0]   rd_d, rdata_q;
  logic            rvalid_q;

  assign in_range  = (id_i < ID_W'(N));
  assign idx       = id_i[IW-1:0];
  assign may_touch = in_range && (sec_i || grp_q[idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      grp_q   <= '0;
      pr_q    <= '0;
      route_q <= 1'b1;
    end else if (wr_i) begin
      unique case (fld_i)
        FLD_ENABLE: if (may_touch) en_q[idx] <= wdata_i[0];
        FLD_PRIO:   if (may_touch) pr_q[idx*PW +: PW] <= wdata_i;
        FLD_GROUP:  if (in_range && sec_i) grp_q[idx] <= wdata_i[0];
        FLD_ROUTE:  if (sec_i) route_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (fld_i)
      FLD_ENABLE: if (may_touch) rd_d = PW'(en_q[idx]);
      FLD_PRIO:   if (may_touch) rd_d = pr_q[idx*PW +: PW];
      FLD_GROUP:  if (in_range && sec_i) rd_d = PW'(grp_q[idx]);
      FLD_ROUTE:  if (sec_i) rd_d = PW'(route_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_d;
    end
  end

  assign en_o        = en_q;
  assign grp_o       = grp_q;
  assign prio_o      = pr_q;
  assign route_fiq_o = route_q;
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;

  p_ns_secure_fields_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !sec_i) |=> ($stable(grp_q) && $stable(route_q)));

  p_ns_grp0_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !sec_i && in_range && !grp_q[idx]) |=> ($stable(en_q) && $stable(pr_q)));

  p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
endmodule

// File: rtl/sgrp_arb.sv
module sgrp_arb #(
  parameter int N  = 8,
  parameter int PW = 4
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            win_valid_o,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] win_idx_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] best;

  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best        = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!win_valid_o || prio_i[i*PW +: PW] < best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IW'(i);
        best        = prio_i[i*PW +: PW];
      end
    end
  end

  always_comb begin
    if (win_valid_o) a_winner_is_candidate_r2: assert (cand_i[win_idx_o]);
  end
endmodule

// File: rtl/sgrp_cpu.sv
module sgrp_cpu
  import sgrp_pkg::*;
#(
  parameter int N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_valid_i,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0] win_idx_i,
  input  logic            win_grp_i,
  input  logic            route_fiq_i,
  input  logic            ack_i,
  input  logic            ack_sec_i,
  input  logic            eoi_i,
  input  logic [ID_W-1:0] eoi_id_i,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            ack_valid_o,
  output logic [ID_W-1:0] ack_id_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          active_q;
  logic [IW-1:0] active_id_q;
  logic          show, ack_take, eoi_hit;
  logic          irq_q, fiq_q, ackv_q;
  logic [ID_W-1:0] ackid_q;

  assign show     = win_valid_i && !active_q;
  assign ack_take = ack_i && show && (ack_sec_i || win_grp_i);
  assign eoi_hit  = eoi_i && active_q && (eoi_id_i == ID_W'(active_id_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      active_id_q <= '0;
      irq_q       <= 1'b0;
      fiq_q       <= 1'b0;
      ackv_q      <= 1'b0;
      ackid_q     <= SPURIOUS_ID;
    end else begin
      if (ack_take) begin
        active_q    <= 1'b1;
        active_id_q <= win_idx_i;
      end else if (eoi_hit) begin
        active_q <= 1'b0;
      end
      irq_q  <= show && !ack_take && (win_grp_i || !route_fiq_i);
      fiq_q  <= show && !ack_take && !win_grp_i && route_fiq_i;
      ackv_q <= ack_i;
      if (ack_i) ackid_q <= ack_take ? ID_W'(win_idx_i) : SPURIOUS_ID;
    end
  end

  assign irq_o       = irq_q;
  assign fiq_o       = fiq_q;
  assign ack_valid_o = ackv_q;
  assign ack_id_o    = ackid_q;

  p_lines_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));

  p_fiq_only_secure_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid_i && win_grp_i) |=> !fiq_o);

  p_ack_when_active_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && active_q) |=> (ack_id_o == SPURIOUS_ID));

  p_ack_silences_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (!irq_o && !fiq_o));

  p_eoi_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> !active_q);
endmodule

// File: rtl/sgrp_irq_dist.sv
module sgrp_irq_dist
  import sgrp_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_level_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_sec_i,
  input  logic [1:0]        reg_fld_i,
  input  logic [9:0]        reg_id_i,
  input  logic [PRIO_W-1:0] reg_wdata_i,
  output logic              rd_valid_o,
  output logic [PRIO_W-1:0] rd_data_o,
  input  logic              ack_i,
  input  logic              ack_sec_i,
  output logic              ack_valid_o,
  output logic [9:0]        ack_id_o,
  input  logic              eoi_i,
  input  logic [9:0]        eoi_id_i,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]        en, grp;
  logic [N_SRC*PRIO_W-1:0] prio;
  logic                    route_fiq, win_valid;
  logic [IW-1:0]           win_idx;

  sgrp_cfg #(.N(N_SRC), .PW(PRIO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .sec_i(reg_sec_i), .fld_i(fld_e'(reg_fld_i)), .id_i(reg_id_i),
    .wdata_i(reg_wdata_i), .en_o(en), .grp_o(grp), .prio_o(prio),
    .route_fiq_o(route_fiq), .rvalid_o(rd_valid_o), .rdata_o(rd_data_o)
  );

  sgrp_arb #(.N(N_SRC), .PW(PRIO_W)) u_arb (
    .cand_i(src_level_i & en), .prio_i(prio),
    .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  sgrp_cpu #(.N(N_SRC)) u_cpu (
    .clk(clk), .rst_n(rst_n), .win_valid_i(win_valid), .win_idx_i(win_idx),
    .win_grp_i(grp[win_idx]), .route_fiq_i(route_fiq), .ack_i(ack_i),
    .ack_sec_i(ack_sec_i), .eoi_i(eoi_i), .eoi_id_i(eoi_id_i),
    .irq_o(irq_o), .fiq_o(fiq_o), .ack_valid_o(ack_valid_o), .ack_id_o(ack_id_o)
  );
endmodule

// File: tb/sgrp_irq_dist_tb.sv
module sgrp_irq_dist_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic wr = 0, rd = 0, sec = 0, ack = 0, ack_sec = 0, eoi = 0;
  logic [1:0] fld = 0;
  logic [9:0] rid = 0, eoi_id = 0;
  logic [PW-1:0] wdata = 0;
  logic rd_valid, ack_valid, irq, fiq;
  logic [PW-1:0] rd_data;
  logic [9:0] ack_id;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_en = '0, m_grp = '0;
  logic [PW-1:0] m_pr [N];
  logic m_route = 1'b1, m_active = 1'b0;
  int m_act_id = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgrp_irq_dist #(.N_SRC(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_level_i(src), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_sec_i(sec), .reg_fld_i(fld), .reg_id_i(rid), .reg_wdata_i(wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ack_i(ack), .ack_sec_i(ack_sec),
    .ack_valid_o(ack_valid), .ack_id_o(ack_id), .eoi_i(eoi), .eoi_id_i(eoi_id),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int winner();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (src[i] && m_en[i] && (w < 0 || m_pr[i] < m_pr[w])) w = i;
    return w;
  endfunction

  task automatic reg_write(input bit s, input int f, input int id, input int d);
    sec = s; fld = 2'(f); rid = 10'(id); wdata = PW'(d); wr = 1;
    tick();
    wr = 0;
    if (f == 3) begin
      if (s) m_route = d[0];
    end else if (id < N) begin
      if (f == 2) begin
        if (s) m_grp[id] = d[0];
      end else if (s || m_grp[id]) begin
        if (f == 0) m_en[id] = d[0];
        else m_pr[id] = PW'(d);
      end
    end
  endtask

  task automatic reg_read(input bit s, input int f, input int id, input string req);
    int e = 0;
    sec = s; fld = 2'(f); rid = 10'(id); rd = 1;
    tick();
    rd = 0;
    if (f == 3) e = s ? int'(m_route) : 0;
    else if (id < N) begin
      if (f == 2) e = s ? int'(m_grp[id]) : 0;
      else if (s || m_grp[id]) e = (f == 0) ? int'(m_en[id]) : int'(m_pr[id]);
    end
    check({req, " rd_valid"}, int'(rd_valid), 1);
    check({req, " rd_data"}, int'(rd_data), e);
  endtask

  task automatic check_lines(input string req);
    int w = winner();
    bit show = (w >= 0) && !m_active;
    bit g1 = (w >= 0) ? m_grp[w] : 1'b0;
    check({req, " irq"}, int'(irq), int'(show && (g1 || !m_route)));
    check({req, " fiq"}, int'(fiq), int'(show && !g1 && m_route));
  endtask

  task automatic do_ack(input bit s, input string req);
    int w = winner();
    int e = 1023;
    if (w >= 0 && !m_active && (s || m_grp[w])) begin
      e = w; m_active = 1; m_act_id = w;
    end
    ack_sec = s; ack = 1;
    tick();
    ack = 0;
    check({req, " ack_valid"}, int'(ack_valid), 1);
    check({req, " ack_id"}, int'(ack_id), e);
  endtask

  task automatic do_eoi(input int id);
    eoi_id = 10'(id); eoi = 1;
    tick();
    eoi = 0;
    if (m_active && id == m_act_id) m_active = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) m_pr[i] = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 fiq", int'(fiq), 0);
    check("R1 ack_valid", int'(ack_valid), 0);
    reg_read(1, 3, 0, "R1 route");
    reg_read(1, 2, 5, "R1 group");
    reg_read(1, 1, 2, "R1 prio");
    // R2 tie: same priority, lowest ID wins; secure routed to FIQ (R3)
    reg_write(1, 0, 3, 1); reg_write(1, 0, 6, 1);
    src = 8'b0100_1000; tick(); tick();
    check_lines("R3 secure to fiq");
    do_ack(1, "R2 tie");
    check("R2 tie id", int'(ack_id), 3);
    check_lines("R7 lines low after ack");
    do_ack(1, "R8 already active");
    do_eoi(5);
    tick();
    check_lines("R9 wrong eoi ignored");
    do_eoi(3);
    tick();
    check_lines("R10 resignal");
    // R2 priority order
    reg_write(1, 1, 6, 2); reg_write(1, 1, 3, 9); tick();
    do_ack(1, "R2 lower prio value wins");
    do_eoi(6);
    // R4 non-secure cannot move group or routing
    reg_write(0, 2, 3, 1); reg_write(0, 3, 0, 0);
    reg_read(1, 2, 3, "R4 group unchanged");
    reg_read(1, 3, 0, "R4 route unchanged");
    reg_read(0, 3, 0, "R4 ns route reads 0");
    // R5 non-secure vs group 0 fields
    reg_write(0, 0, 3, 0);
    reg_read(1, 0, 3, "R5 enable kept");
    reg_read(0, 1, 6, "R5 ns prio of grp0 reads 0");
    reg_read(1, 1, 9, "R5 out of range");
    // R8 non-secure ack of group 0 winner
    do_ack(0, "R8 ns ack of secure");
    // R3 group 1 only irq, route to irq
    reg_write(1, 2, 3, 1); reg_write(1, 2, 6, 1); tick();
    check_lines("R3 group1 irq");
    reg_write(0, 1, 3, 1); reg_read(0, 1, 3, "R5 ns prio grp1");
    src = '0; tick(); tick();
    do_ack(1, "R8 nothing pending");
    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4)
        reg_write(bit'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, N), $urandom_range(0, 15));
      else if (op < 6)
        reg_read(bit'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, N), "R6 random read");
      src = N'($urandom_range(0, 255));
      tick();
      check_lines("R3 random lines");
      if (op == 7) do_ack(bit'($urandom_range(0, 1)), "R7 random ack");
      if (op == 8) begin
        do_eoi($urandom_range(0, 1) ? m_act_id : $urandom_range(0, N));
        tick();
        check_lines("R9 random eoi");
      end
    end
    finish_run();
  end
endmodule